// File: doc/BRIEF.md
# Two-Group Priority Interrupt Controller

This block collects fifteen interrupt request lines, numbered 1 through 15, and turns them into a single 4-bit interrupt number for the first processor. A rising edge on a request line is latched in a pending register. If the line is marked for broadcast, the edge instead sets that line's bit in the force register of every processor. Software can also force interrupts itself, using a set/clear write format. It can clear latched requests, and it gates the lines with a per-processor mask. A level register divides the lines into a high group and a low group. Whenever any unmasked high-group line is active, the high group is served.

Within the served group, the highest-numbered active line wins. Its number is registered onto the output. The processor returns a single-cycle acknowledge strobe with an interrupt number, and that line's latched and forced state for processor 0 is removed. Software reaches the block through a 256-byte window of 32-bit registers. Reads return data in the same cycle. Writes take effect at the next clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Line 0 does not exist. Bit 0 of every register that holds line bits is always zero, whatever value is written, and input irq_i[0] is ignored.
- R2: Byte address bits 1:0 are ignored. Word offsets are as follows:
  - 0x00 is the group register, where bit n = 1 puts line n in the high group.
  - 0x04 is the pending register.
  - 0x08 is an alias of processor 0's force register, and a write there replaces its contents.
  - 0x14 is the broadcast register.
  - 0x40 + 4·c is the mask of processor c.
  - 0x80 + 4·c is the force register of processor c.
  - 0xC0 + 4·c is a 4-bit spare register of processor c, which keeps wdata[3:0].
  - Line registers are 16 bits wide, and read bits 31:16 are zero.
- R3: A rising edge on irq_i[n], with broadcast bit n clear, sets pending bit n in the next cycle. A line held high sets the bit only once.
- R4: A rising edge on irq_i[n], with broadcast bit n set, sets force bit n of every processor and leaves pending bit n unchanged.
- R5: The effective set is (pending OR force0) AND mask0. The high group is the effective set masked by the group register, and it is served when nonzero; otherwise the rest of the effective set is served. irq_num_o is the highest set bit index of the served group, or 0 when that group is empty. irq_num_o is registered and reflects the state one cycle earlier.
- R6: A write to a per-processor force register sets the bits in wdata[15:1] and then clears the bits in wdata[31:17]. A bit named in both ends up cleared.
- R7: A write to 0x0C clears the pending bits given in wdata[15:1]. Offsets 0x0C and 0x10 read as zero. Writes to 0x04 and 0x10 change nothing.
- R8: ack_i with ack_num_i = n clears pending bit n and force bit n of processor 0. An acknowledge of 0 changes nothing.
- R9: When an edge sets a pending or force bit in the same cycle that a clear write or an acknowledge removes it, the bit ends up set.
- R10: After reset, every register reads zero and irq_num_o is 0.
- R11: Unmapped offsets read zero and ignore writes. This includes 0x18–0x3C and the per-processor slots for c ≥ NCPU.
- R12: Only processor 0's mask and force feed irq_num_o. The state of other processors has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Request lines; bit 0 unused |
| ack_i | input | 1 | Single-cycle acknowledge strobe |
| ack_num_i | input | 4 | Acknowledged interrupt number |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address in the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| irq_num_o | output | 4 | Selected interrupt number for processor 0 |

## Verification
The assertions check several properties on every cycle:
- A pending-register write changes nothing.
- A fresh edge lands in pending or in the force registers, according to its broadcast bit.
- An acknowledge removes its line.
- An empty effective set yields a zero output.

Only the bench scenarios can show the group precedence and the highest-number choice within a group. They also cover the ordering of set and clear halves in force writes, the set-over-clear collisions, the unmapped and out-of-range slots, and the independence from other processors. There a behavioural model tracks every register and the output each cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int LINES  = 16;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;
   localparam int NUM_W  = $clog2(LINES);
   localparam logic [LINES-1:0] LINE_MASK = {{(LINES-1){1'b1}}, 1'b0};

   typedef logic [LINES-1:0] lvec_t;

   // window regions selected by address bits 7:6
   typedef enum logic [1:0] {
      RG_GLOBAL = 2'd0,
      RG_MASK   = 2'd1,
      RG_FORCE  = 2'd2,
      RG_SPARE  = 2'd3
   } region_e;

   // word slots inside the global region
   localparam logic [3:0] GW_GROUP  = 4'd0;
   localparam logic [3:0] GW_PEND   = 4'd1;
   localparam logic [3:0] GW_FORCE0 = 4'd2;
   localparam logic [3:0] GW_CLEAR  = 4'd3;
   localparam logic [3:0] GW_STATUS = 4'd4;
   localparam logic [3:0] GW_BCAST  = 4'd5;

   function automatic logic [NUM_W-1:0] top_index(lvec_t v);
      logic [NUM_W-1:0] r;
      r = '0;
      for (int i = 1; i < LINES; i++)
         if (v[i]) r = NUM_W'(i);
      return r;
   endfunction
endpackage

// File: rtl/prio_irq_edge.sv
module prio_irq_edge #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
   import prio_irq_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lvec_t             rise_i,
   input  logic              ack_i,
   input  logic [NUM_W-1:0]  ack_num_i,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output lvec_t             group_o,
   output lvec_t             pend_o,
   output lvec_t             force0_o,
   output lvec_t             mask0_o
);
   localparam int SPARE_W = 4;

   lvec_t group_q, pend_q, bcast_q;
   logic [NCPU*LINES-1:0]   force_all, mask_all;
   logic [NCPU*SPARE_W-1:0] spare_all;

   region_e    region;
   logic [3:0] slot;
   logic       we;
   lvec_t      wlo, whi, ack_m, bc_rise;

   assign region  = region_e'(addr_i[7:6]);
   assign slot    = addr_i[5:2];
   assign we      = sel_i & wr_i;
   assign wlo     = wdata_i[LINES-1:0] & LINE_MASK;
   assign whi     = wdata_i[DATA_W-1:DATA_W-LINES] & LINE_MASK;
   assign ack_m   = ack_i ? (lvec_t'(1) << ack_num_i) : '0;
   assign bc_rise = rise_i & bcast_q;

   // global registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         group_q <= '0;
         pend_q  <= '0;
         bcast_q <= '0;
      end else begin
         if (we && region == RG_GLOBAL && slot == GW_GROUP) group_q <= wlo;
         if (we && region == RG_GLOBAL && slot == GW_BCAST) bcast_q <= wlo;
         pend_q <= (pend_q & ~ack_m
                    & ~((we && region == RG_GLOBAL && slot == GW_CLEAR) ? wlo : '0))
                   | (rise_i & ~bcast_q);
      end
   end

   // per-processor registers
   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      localparam bit IS0 = (c == 0);
      lvec_t               force_q, mask_q, force_nx;
      logic [SPARE_W-1:0]  spare_q;
      logic                hit;

      assign hit = (slot == 4'(c));

      always_comb begin
         force_nx = force_q;
         if (IS0 && we && region == RG_GLOBAL && slot == GW_FORCE0) force_nx = wlo;
         if (we && region == RG_FORCE && hit) force_nx = (force_nx | wlo) & ~whi;
         if (IS0) force_nx = force_nx & ~ack_m;
         force_nx = force_nx | bc_rise;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            force_q <= '0;
            mask_q  <= '0;
            spare_q <= '0;
         end else begin
            force_q <= force_nx;
            if (we && region == RG_MASK && hit)  mask_q  <= wlo;
            if (we && region == RG_SPARE && hit) spare_q <= wdata_i[SPARE_W-1:0];
         end
      end

      assign force_all[c*LINES +: LINES]     = force_q;
      assign mask_all[c*LINES +: LINES]      = mask_q;
      assign spare_all[c*SPARE_W +: SPARE_W] = spare_q;
   end

   // read mux
   always_comb begin
      rdata_o = '0;
      if (sel_i && !wr_i) begin
         unique case (region)
            RG_GLOBAL: begin
               case (slot)
                  GW_GROUP:  rdata_o = DATA_W'(group_q);
                  GW_PEND:   rdata_o = DATA_W'(pend_q);
                  GW_FORCE0: rdata_o = DATA_W'(force_all[LINES-1:0]);
                  GW_BCAST:  rdata_o = DATA_W'(bcast_q);
                  default:   rdata_o = '0;
               endcase
            end
            RG_MASK:
               for (int c = 0; c < NCPU; c++)
                  if (slot == 4'(c)) rdata_o = DATA_W'(mask_all[c*LINES +: LINES]);
            RG_FORCE:
               for (int c = 0; c < NCPU; c++)
                  if (slot == 4'(c)) rdata_o = DATA_W'(force_all[c*LINES +: LINES]);
            RG_SPARE:
               for (int c = 0; c < NCPU; c++)
                  if (slot == 4'(c)) rdata_o = DATA_W'(spare_all[c*SPARE_W +: SPARE_W]);
            default: rdata_o = '0;
         endcase
      end
   end

   assign group_o  = group_q;
   assign pend_o   = pend_q;
   assign force0_o = force_all[LINES-1:0];
   assign mask0_o  = mask_all[LINES-1:0];

   // a write to the pending slot must leave pending untouched
   p_pend_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && region == RG_GLOBAL && slot == GW_PEND && rise_i == '0 && !ack_i)
      |=> $stable(pend_q));

   p_edge_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise_i & ~bcast_q))
      |=> ((pend_q & $past(rise_i & ~bcast_q)) == $past(rise_i & ~bcast_q)));

   p_bcast_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|bc_rise)
      |=> ((force0_o & $past(bc_rise)) == $past(bc_rise)));

   p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !rise_i[ack_num_i])
      |=> (!pend_q[$past(ack_num_i)] && !force0_o[$past(ack_num_i)]));
endmodule

// File: rtl/prio_irq_sel.sv
module prio_irq_sel
   import prio_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  lvec_t            pend_i,
   input  lvec_t            force_i,
   input  lvec_t            mask_i,
   input  lvec_t            group_i,
   output logic [NUM_W-1:0] num_o
);
   lvec_t eff, hi, lo, served;

   assign eff    = (pend_i | force_i) & mask_i;
   assign hi     = eff & group_i;
   assign lo     = eff & ~group_i;
   assign served = (hi != '0) ? hi : lo;

   always_ff @(posedge clk) begin
      if (!rst_n) num_o <= '0;
      else        num_o <= top_index(served);
   end

   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eff == '0) |=> (num_o == '0));

   p_active_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eff != '0) |=> (num_o != '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       irq_i,
   input  logic              ack_i,
   input  logic [3:0]        ack_num_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [7:0]        bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic [3:0]        irq_num_o
);
   if (NCPU < 1 || NCPU > 16) begin : g_bad_ncpu
      $error("NCPU must lie in 1..16");
   end

   lvec_t rise, group, pend, force0, mask0;

   prio_irq_edge #(.W(LINES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (irq_i & LINE_MASK),
      .rise_o (rise)
   );

   prio_irq_regs #(.NCPU(NCPU)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise),
      .ack_i     (ack_i),
      .ack_num_i (ack_num_i),
      .sel_i     (bus_sel_i),
      .wr_i      (bus_wr_i),
      .addr_i    (bus_addr_i),
      .wdata_i   (bus_wdata_i),
      .rdata_o   (bus_rdata_o),
      .group_o   (group),
      .pend_o    (pend),
      .force0_o  (force0),
      .mask0_o   (mask0)
   );

   prio_irq_sel u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend),
      .force_i (force0),
      .mask_i  (mask0),
      .group_i (group),
      .num_o   (irq_num_o)
   );
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;

   logic        clk = 0, rst_n = 0;
   logic [15:0] irq = 0;
   logic        ack = 0;
   logic [3:0]  ack_num = 0;
   logic        sel = 0, wr = 0;
   logic [7:0]  addr = 0;
   logic [31:0] wdata = 0;
   logic [31:0] rdata;
   logic [3:0]  num;

   int checks = 0, fails = 0;
   string cur_req = "R10";

   prio_irq_ctrl #(.NCPU(NC)) uut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .ack_i(ack), .ack_num_i(ack_num),
      .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_num_o(num)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   int unsigned m_grp, m_pend, m_bc, m_prev, m_out;
   int unsigned m_mask[16], m_force[16], m_spare[16];

   function automatic int unsigned top_of(int unsigned v);
      int unsigned r = 0;
      for (int i = 1; i < 16; i++) if (v[i]) r = i;
      return r;
   endfunction

   function automatic int unsigned model_read(int unsigned a);
      int unsigned w = a & 'hFC;
      int unsigned k = (w & 'h3C) >> 2;
      if (w == 'h00) return m_grp;
      if (w == 'h04) return m_pend;
      if (w == 'h08) return m_force[0];
      if (w == 'h14) return m_bc;
      if (w >= 'h40 && w < 'h80) return (k < NC) ? m_mask[k] : 0;
      if (w >= 'h80 && w < 'hC0) return (k < NC) ? m_force[k] : 0;
      if (w >= 'hC0) return (k < NC) ? m_spare[k] : 0;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_grp = 0; m_pend = 0; m_bc = 0; m_prev = 0; m_out = 0;
         for (int i = 0; i < 16; i++) begin m_mask[i] = 0; m_force[i] = 0; m_spare[i] = 0; end
      end else begin
         int unsigned eff, hi, rise, clr, am, w, k, lo16, hi16;
         eff = (m_pend | m_force[0]) & m_mask[0];
         hi  = eff & m_grp;
         m_out = top_of(hi != 0 ? hi : (eff & ~m_grp));
         rise = irq & ~m_prev & 'hFFFE;
         m_prev = irq;
         clr = 0;
         lo16 = wdata[15:0] & 'hFFFE;
         hi16 = wdata[31:16] & 'hFFFE;
         if (sel && wr) begin
            w = addr & 'hFC; k = (w & 'h3C) >> 2;
            if (w == 'h00) m_grp = lo16;
            else if (w == 'h08) m_force[0] = lo16;
            else if (w == 'h0C) clr = lo16;
            else if (w == 'h14) m_bc = lo16;  // m_bc used below is new; fix ordering
            else if (w >= 'h40 && w < 'h80 && k < NC) m_mask[k] = lo16;
            else if (w >= 'h80 && w < 'hC0 && k < NC) m_force[k] = (m_force[k] | lo16) & ~hi16;
            else if (w >= 'hC0 && k < NC) m_spare[k] = wdata[3:0];
         end
         am = ack ? (1 << ack_num) : 0;
         m_force[0] = m_force[0] & ~am;
         m_pend = (m_pend & ~clr & ~am) | (rise & ~bc_before);
         for (int c = 0; c < NC; c++) m_force[c] = m_force[c] | (rise & bc_before);
      end
   end

   // broadcast value before this edge's write (register takes effect next cycle)
   int unsigned bc_before;
   always @(negedge clk) bc_before = m_bc;

   task automatic check(string what, int unsigned act, int unsigned exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("irq_num_o", num, m_out);
         if (sel && !wr) check($sformatf("read @%0h", addr), rdata, model_read(addr));
      end
   end

   task automatic idle();
      @(posedge clk); #1;
      sel = 0; wr = 0; ack = 0;
   endtask
   task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      sel = 1; wr = 1; addr = a; wdata = d; ack = 0;
      idle();
   endtask
   task automatic bread(input logic [7:0] a);
      @(posedge clk); #1;
      sel = 1; wr = 0; addr = a; ack = 0;
      idle();
   endtask
   task automatic do_ack(input logic [3:0] n);
      @(posedge clk); #1;
      ack = 1; ack_num = n;
      idle();
   endtask
   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      wait_n(3);
      rst_n = 1;
      // R10: everything zero after reset
      cur_req = "R10";
      wait_n(1);
      check("irq_num_o after reset", num, 0);
      for (int a = 0; a < 256; a += 4) bread(8'(a));

      // R1 / R2: readback with bit 0 and upper bits stripped
      cur_req = "R1";
      bwrite(8'h00, 32'hFFFF_FFFF); bread(8'h00);
      bwrite(8'h14, 32'hFFFF_FFFF); bread(8'h14);
      cur_req = "R2";
      bwrite(8'h45, 32'h1234_ABCD); bread(8'h44);
      bwrite(8'hC8, 32'hFF);        bread(8'hC8);
      bwrite(8'h8C, 32'h0000_00F0); bread(8'h8C);
      bwrite(8'h00, 0); bwrite(8'h14, 0);
      bwrite(8'h8C, 32'hFFFF_0000); bread(8'h8C);
      bwrite(8'h40, 32'hFFFF);

      // R3: edge latches once; held line does not re-latch after clear
      cur_req = "R3";
      @(posedge clk); #1; irq = 16'h0021;   // bit 0 ignored (R1)
      wait_n(3); bread(8'h04);
      bwrite(8'h0C, 32'h20); wait_n(3); bread(8'h04);
      irq = 0; wait_n(2);

      // R5: group precedence and highest-number choice
      cur_req = "R5";
      @(posedge clk); #1; irq = 16'h0208; wait_n(1); irq = 0; wait_n(3);
      bwrite(8'h00, 32'h0008); wait_n(3);
      bwrite(8'h00, 32'h0000); wait_n(3);

      // R8: acknowledge clears pending and force0
      cur_req = "R8";
      do_ack(4'd9); wait_n(2); bread(8'h04);
      do_ack(4'd0); wait_n(2); bread(8'h04);
      do_ack(4'd3); wait_n(2);

      // R7: clear/status read zero, pending write ignored
      cur_req = "R7";
      @(posedge clk); #1; irq = 16'h4000; wait_n(1); irq = 0;
      bwrite(8'h04, 32'h0); bread(8'h04);
      bwrite(8'h10, 32'hFFFF); bread(8'h10); bread(8'h0C);
      bwrite(8'h0C, 32'h4000); bread(8'h04);

      // R6: set then clear, clear wins; alias write replaces
      cur_req = "R6";
      bwrite(8'h80, 32'h0010_0030); bread(8'h80); wait_n(2);
      bwrite(8'h08, 32'h0000_1001); bread(8'h80); wait_n(2);
      bwrite(8'h80, 32'hFFFF_0000); bread(8'h08);

      // R4: broadcast edge sets force everywhere, not pending
      cur_req = "R4";
      bwrite(8'h14, 32'h0080);
      @(posedge clk); #1; irq = 16'h0080; wait_n(1); irq = 0; wait_n(2);
      bread(8'h04); bread(8'h80); bread(8'h84); bread(8'h8C);
      do_ack(4'd7); wait_n(2); bread(8'h80); bread(8'h84);
      bwrite(8'h14, 0);

      // R9: set beats clear in the same cycle
      cur_req = "R9";
      @(posedge clk); #1;
      irq = 16'h0010; sel = 1; wr = 1; addr = 8'h0C; wdata = 32'h10;
      idle(); irq = 0; bread(8'h04); wait_n(2);
      @(posedge clk); #1; irq = 16'h0010; ack = 1; ack_num = 4;
      idle(); irq = 0; bread(8'h04); wait_n(2);
      bwrite(8'h0C, 32'hFFFF);

      // R11: unmapped and out-of-range slots
      cur_req = "R11";
      bwrite(8'h18, 32'hFFFF); bread(8'h18); bread(8'h3C);
      bwrite(8'h50, 32'hFFFF); bread(8'h50);
      bwrite(8'h90, 32'hFFFF); bread(8'h90);
      bwrite(8'hD0, 32'hF);    bread(8'hD0);
      wait_n(2);

      // R12: other processors have no effect on output
      cur_req = "R12";
      bwrite(8'h84, 32'h1000); bwrite(8'h44, 32'hFFFF); wait_n(3);
      check("irq_num_o with cpu1 forced", num, 0);
      bwrite(8'h40, 32'h0000); bwrite(8'h08, 32'h0004); wait_n(3);
      check("irq_num_o with mask0 zero", num, 0);
      bwrite(8'h40, 32'hFFFF); wait_n(3);
      check("irq_num_o force0 line 2", num, 2);

      wait_n(5);
      finish_run();
   end
endmodule